// File: doc/BRIEF.md
# Program Counter and Equality-Branch Unit

This block holds the program counter of a single-cycle 64-bit processor that runs a small RISC-style instruction subset. In every cycle it reads the current instruction word and the two register operands that the register file supplies for it. It builds a sign-extended immediate from that word and decides whether the instruction is an equality branch whose operands match. At the next rising clock edge it moves the program counter either to the following word, at PC+4, or to the branch target.

The immediate generator does not decode the full opcode. It selects fields using only opcode bits 6 and 5. The left shift of the branch offset is built into where the bits are placed, so the target is simply the PC plus the immediate. The immediate and the taken flag are combinational outputs of the current instruction. The program counter is the only state in the block. The register file, the data memory, the rest of the control logic and execution of all other instructions sit outside this block.

Top module: `fetch_branch_unit`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the PC becomes 0. This holds at any time, including in the middle of a run.
- R2: When the branch is not taken, the PC increases by 4 at each rising edge. The addition wraps modulo 2^64.
- R3: When the branch is taken, the PC becomes PC + `imm_o` at the rising edge. The addition wraps modulo 2^64, so negative offsets move the PC backwards.
- R4: `taken_o` is 1 exactly when all of the following hold: the opcode `instr[6:0]` is 1100011, the funct3 field `instr[14:12]` is 000, and the two operands are equal across all 64 bits.
- R5: For any opcode other than 1100011, `taken_o` is 0 even when the operands are equal.
- R6: For the register-immediate ALU opcode 0010011 and the load opcode 0000011, `imm_o` is `instr[31:20]` sign-extended to 64 bits.
- R7: For the store opcode 0100011, `imm_o` is `{instr[31:25], instr[11:7]}` sign-extended to 64 bits.
- R8: For opcode 1100011, `imm_o` is the 13-bit offset `{instr[31], instr[7], instr[30:25], instr[11:8], 0}` sign-extended to 64 bits. Bit 0 is always 0.
- R9: The word 0x00628463 (equality branch, rs1 = 5, rs2 = 6) gives `imm_o` = 8.
- R10: An instruction with opcode 1100011 and a nonzero funct3 still produces the branch immediate. It is not taken, even with equal operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Current instruction word |
| opnd_a | input | 64 | First register operand (rs1 value) |
| opnd_b | input | 64 | Second register operand (rs2 value) |
| pc_o | output | 64 | Current program counter |
| imm_o | output | 64 | Sign-extended immediate of `instr` |
| taken_o | output | 1 | Equality branch taken this cycle |

## Verification
The bench builds the block with its default width, XLEN = 64. At this width, the full 52-bit sign extension above bit 11 is observable. So is the wrap of the program counter through zero when a backward branch is taken from a small PC. The operand pairs include values that differ only in bit 63. This shows that the subtract-and-zero test covers the whole word and not only the low bits. Every instruction word is encoded in the bench from the offset it intends to carry, and that intended offset is the expected immediate.

// File: rtl/fbu_pkg.sv
// Shared constants for the fetch/branch unit: opcode values, funct3 value
// of the equality branch, and the two-bit immediate format selector.
package fbu_pkg;
    localparam int INSTR_W = 32;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_ALUI   = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [2:0] F3_EQ      = 3'b000;

    // Selector formed from opcode bits {6,5}
    typedef enum logic [1:0] {
        FMT_I   = 2'b00,
        FMT_S   = 2'b01,
        FMT_RSV = 2'b10,
        FMT_SB  = 2'b11
    } imm_sel_e;
endpackage

// File: rtl/fbu_imm_builder.sv
// Immediate builder. Assembles a sign-extended XLEN-bit immediate from the
// instruction using only opcode bits 6 and 5 as selects. The branch offset
// shift is folded into the bit placement (bit 0 forced to 0 for branches).
// Assumes XLEN > 12. Output is undefined in meaning for other formats.
module fbu_imm_builder
    import fbu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [INSTR_W-1:0] instr,
    output logic [XLEN-1:0]    imm
);
    localparam int EXT_W = XLEN - 12;

    imm_sel_e   sel;
    logic       bit0;
    logic [3:0] bits4_1;
    logic       bit11;

    assign sel = imm_sel_e'(instr[6:5]);

    // Bit 0: source depends on both select bits
    always_comb begin
        case (sel)
            FMT_I:   bit0 = instr[20];
            FMT_S:   bit0 = instr[7];
            default: bit0 = 1'b0;
        endcase
    end

    // Bits 4..1: chosen by opcode bit 5 alone
    assign bits4_1 = instr[5] ? instr[11:8] : instr[24:21];

    // Bit 11: chosen by opcode bit 6 alone
    assign bit11 = instr[6] ? instr[7] : instr[31];

    // Assemble: sign replication, bit 11, shared bits 10..5, low bits
    assign imm = {{EXT_W{instr[31]}}, bit11, instr[30:25], bits4_1, bit0};
endmodule

// File: rtl/fbu_branch_cond.sv
// Branch condition. Subtracts the operands and tests for a zero result;
// qualifies with the equality-branch opcode and funct3.
// Assumes operands are already read from the register file this cycle.
module fbu_branch_cond
    import fbu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [XLEN-1:0]    opnd_a,
    input  logic [XLEN-1:0]    opnd_b,
    output logic               taken
);
    logic [XLEN-1:0] diff;
    logic            is_zero;
    logic            is_beq;

    // Difference of the operands, as an ALU subtract would give it
    assign diff    = opnd_a - opnd_b;
    assign is_zero = ~|diff;

    // Instruction qualifies as equality branch
    assign is_beq = (instr[6:0] == OPC_BRANCH) && (instr[14:12] == F3_EQ);

    assign taken = is_beq & is_zero;
endmodule

// File: rtl/fbu_pc_seq.sv
// Program counter register with next-address selection between the
// sequential address and the branch target. Synchronous active-low reset
// to zero. Arithmetic wraps modulo 2^XLEN.
module fbu_pc_seq
    import fbu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            taken,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] pc
);
    localparam int              STEP_BYTES = INSTR_W / 8;
    localparam logic [XLEN-1:0] STEP       = XLEN'(STEP_BYTES);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] tgt_addr;

    assign seq_addr = pc_q + STEP;
    assign tgt_addr = pc_q + imm;

    // Load next PC, or zero under reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= taken ? tgt_addr : seq_addr;
        end
    end

    assign pc = pc_q;
endmodule

// File: rtl/fetch_branch_unit.sv
// Top of the fetch/branch unit. Joins the immediate builder, the equality
// condition and the PC register. Immediate and taken flag are combinational
// in the current instruction; PC changes on the rising edge.
// Assumes the instruction and operands are stable before the edge.
module fetch_branch_unit
    import fbu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [XLEN-1:0]    opnd_a,
    input  logic [XLEN-1:0]    opnd_b,
    output logic [XLEN-1:0]    pc_o,
    output logic [XLEN-1:0]    imm_o,
    output logic               taken_o
);
    logic [XLEN-1:0] imm_w;
    logic            taken_w;

    fbu_imm_builder #(.XLEN(XLEN)) u_imm (
        .instr (instr),
        .imm   (imm_w)
    );

    fbu_branch_cond #(.XLEN(XLEN)) u_cond (
        .instr  (instr),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .taken  (taken_w)
    );

    fbu_pc_seq #(.XLEN(XLEN)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .taken (taken_w),
        .imm   (imm_w),
        .pc    (pc_o)
    );

    assign imm_o   = imm_w;
    assign taken_o = taken_w;
endmodule

// File: rtl/fbu_checker.sv
// Assertion checker for the fetch/branch unit, bound to every instance.
module fbu_checker
    import fbu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic [XLEN-1:0]    opnd_a,
    input logic [XLEN-1:0]    opnd_b,
    input logic [XLEN-1:0]    pc_o,
    input logic [XLEN-1:0]    imm_o,
    input logic               taken_o
);
    AST_PC_RESET: assert property (@(posedge clk)
        !rst_n |=> pc_o == '0); // R1

    AST_PC_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |=> pc_o == $past(pc_o) + XLEN'(4)); // R2

    AST_PC_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> pc_o == $past(pc_o) + $past(imm_o)); // R3

    AST_NEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_a != opnd_b) |-> !taken_o); // R4

    AST_OTHER_OPC_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[6:0] != OPC_BRANCH) |-> !taken_o); // R5

    AST_IMM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        imm_o[XLEN-1] == instr[31]); // R6

    AST_SB_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[6:0] == OPC_BRANCH) |-> !imm_o[0]); // R8

    AST_NONEQ_F3_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[14:12] != F3_EQ) |-> !taken_o); // R10
endmodule

bind fetch_branch_unit fbu_checker #(.XLEN(XLEN)) u_fbu_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .instr   (instr),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .pc_o    (pc_o),
    .imm_o   (imm_o),
    .taken_o (taken_o)
);

// File: tb/fetch_branch_unit_bench.sv
module fetch_branch_unit_bench;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [31:0]     instr;
    logic [XLEN-1:0] opnd_a, opnd_b;
    logic [XLEN-1:0] pc_o, imm_o;
    logic            taken_o;

    int              checks = 0;
    int              errors = 0;
    logic [XLEN-1:0] exp_pc;
    string           prev_tag;

    always #5 clk = ~clk;

    fetch_branch_unit #(.XLEN(XLEN)) u_fetch_branch_unit (
        .clk(clk), .rst_n(rst_n), .instr(instr), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .pc_o(pc_o), .imm_o(imm_o), .taken_o(taken_o)
    );

    // Encoders: build instruction words from an intended offset
    function automatic logic [31:0] enc_i(logic [11:0] off, logic [6:0] opc);
        return {off, 5'd2, 3'b000, 5'd1, opc};
    endfunction
    function automatic logic [31:0] enc_s(logic [11:0] off);
        return {off[11:5], 5'd5, 5'd2, 3'b011, off[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(logic [12:0] off, logic [2:0] f3);
        return {off[12], off[10:5], 5'd6, 5'd5, f3, off[4:1], off[11], 7'b1100011};
    endfunction

    task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive, check combinational outputs and the PC, advance model
    task automatic step(logic [31:0] ins, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                        bit chk_imm, logic [XLEN-1:0] eimm, bit etaken, string tag);
        @(negedge clk);
        rst_n = 1'b1; instr = ins; opnd_a = a; opnd_b = b;
        #1;
        check({prev_tag, " pc"}, pc_o, exp_pc);
        if (chk_imm) check({tag, " imm"}, imm_o, eimm);
        check({tag, " taken"}, {63'd0, taken_o}, {63'd0, etaken});
        exp_pc   = etaken ? exp_pc + eimm : exp_pc + 64'd4;
        prev_tag = etaken ? "R3" : "R2";
    endtask

    task automatic do_reset(int n);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            check("R1 reset pc", pc_o, '0);
        end
        exp_pc   = '0;
        prev_tag = "R1";
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [XLEN-1:0] big;
        big = 64'h8000_0000_0000_0000;
        rst_n = 1'b0; instr = '0; opnd_a = '0; opnd_b = '0;
        exp_pc = '0; prev_tag = "R1";
        do_reset(3);

        // R9: literal word, taken with equal operands (R3)
        step(32'h00628463, 64'd7, 64'd7, 1, 64'd8, 1, "R9");
        // R4: same branch, unequal operands
        step(32'h00628463, 64'd7, 64'd8, 1, 64'd8, 0, "R4 neq");
        // R4: operands differ only in bit 63
        step(enc_b(13'd16, 3'b000), big, 64'd0, 1, 64'd16, 0, "R4 msb");
        // R4: equal large operands taken
        step(enc_b(13'd16, 3'b000), big | 64'd5, big | 64'd5, 1, 64'd16, 1, "R4 eq");
        // R8: max positive branch offset
        step(enc_b(13'd4094, 3'b000), 64'd1, 64'd1, 1, 64'd4094, 1, "R8 max");
        // R8: negative offset -4096, wrap through zero
        step(enc_b(13'h1000, 3'b000), 64'd3, 64'd3, 1, -64'sd4096, 1, "R8 min");
        step(enc_b(13'h1000, 3'b000), 64'd3, 64'd3, 1, -64'sd4096, 1, "R3 wrap");
        // R10: nonzero funct3 not taken, immediate kept
        step(enc_b(13'h1FF8, 3'b001), 64'd9, 64'd9, 1, -64'sd8, 0, "R10");
        // R6: I formats
        step(enc_i(12'hFFF, 7'b0010011), 64'd4, 64'd4, 1, -64'sd1, 0, "R6 alui");
        step(enc_i(12'h7FF, 7'b0010011), 64'd4, 64'd4, 1, 64'd2047, 0, "R6 pos");
        step(enc_i(12'h800, 7'b0000011), 64'd0, 64'd0, 1, -64'sd2048, 0, "R6 load");
        step(enc_i(12'h008, 7'b0000011), 64'd0, 64'd0, 1, 64'd8, 0, "R6 ld8");
        // R7: store formats
        step(enc_s(12'hFF0), 64'd2, 64'd2, 1, -64'sd16, 0, "R7 neg");
        step(enc_s(12'h7FF), 64'd2, 64'd2, 1, 64'd2047, 0, "R7 pos");
        step(enc_s(12'h800), 64'd2, 64'd2, 1, -64'sd2048, 0, "R7 min");
        // R5: register-register add, equal operands, not taken
        step(32'h002081B3, 64'd6, 64'd6, 0, '0, 0, "R5 add");
        step(32'h00628463, 64'd1, 64'd1, 1, 64'd8, 1, "R3 again");
        step(32'h00000013, 64'd0, 64'd0, 1, 64'd0, 0, "R2 nop");
        // R1: reset during run
        do_reset(2);
        step(32'h00000013, 64'd0, 64'd0, 1, 64'd0, 0, "R2 after reset");
        step(32'h00000013, 64'd0, 64'd0, 1, 64'd0, 0, "R2 tail");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule